// File: doc/BRIEF.md
# Variable-Length Effective Address Generator

This block produces the effective memory address for one instruction of a 64-bit accumulator-style processor. A decoder outside the block gives it an addressing-mode code, the instruction prefix byte, the current program counter and the two index registers, then pulses `start`. The block reads the operand bytes that follow the opcode through a byte-wide synchronous read port. It assembles them into an address and applies indexing or a pointer fetch as the mode requires. It then reports the effective address and the program counter that points past the operand bytes.

The number of operand bytes is chosen per instruction by prefix bits [3:2]. The direct and pointer-based short modes use one length table and the absolute mode uses another. Immediate operands are not read. Their address is the program counter itself, and the counter skips either one byte or a power-of-two number of bytes set by prefix bits [7:4]. The block issues at most one read per cycle. It raises `done` for one cycle when `ea` and `pc_out` are valid.

Top module: `eag_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `busy`, `done` and `mem_rd` are all low.
- R2: The `mode` input is coded as follows: 2 zero-page, 3 zero-page+X, 4 zero-page+Y, 5 indirect, 6 X-pre-indexed indirect, 7 Y-post-indexed indirect. For these codes, prefix[3:2] = 0/1/2/3 selects 1/3/6/4 operand bytes. Operand bytes are read starting at `pc_in` and assembled little-endian: the byte at `pc_in` forms bits 7:0, and each following byte forms the next 8 bits. Bits above the last byte read are zero. For code 2, `ea` equals the assembled value.
- R3: For code 8 (absolute), prefix[3:2] = 0/1/2/3 selects 2/5/7/8 operand bytes, assembled as in R2, and `ea` equals the assembled value.
- R4: For codes 2 to 8, `pc_out` equals `pc_in` plus the number of operand bytes read.
- R5: Code 3 adds `x_in` and code 4 adds `y_in` to the assembled value, modulo 2^64.
- R6: Code 5 reads 8 bytes starting at the assembled value, and the little-endian result is `ea`.
- R7: Code 6 adds `x_in` to the assembled value before the 8-byte pointer read. Code 7 adds `y_in` to the pointer after it is read, modulo 2^64.
- R8: For code 1 (immediate), no memory is read and `ea` equals `pc_in`. `pc_out` equals `pc_in`+1 when `imm_one` is high, and `pc_in` + (1 << prefix[7:4]) otherwise. `done` rises in the cycle after `start`.
- R9: For code 0 and codes 9 to 15 (implied), no memory is read, `ea` is 0, `pc_out` equals `pc_in`, and `done` rises in the cycle after `start`.
- R10: Reads use consecutive ascending addresses, one per cycle, and `mem_data` is taken one cycle after `mem_rd`. The total read count is the operand length, plus 8 for codes 5 to 7. `done` lasts exactly one cycle, with `busy` and `mem_rd` low.
- R11: A `start` pulse while `busy` is high is ignored: the result of the running request is unchanged, and no further read or `done` follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one address computation (taken when not busy) |
| mode | input | 4 | Addressing-mode code (see R2, R3, R8, R9) |
| prefix | input | 8 | Instruction prefix byte |
| imm_one | input | 1 | Immediate operand occupies one byte |
| pc_in | input | 64 | Program counter at the first operand byte |
| x_in | input | 64 | X index register |
| y_in | input | 64 | Y index register |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 64 | Byte read address |
| mem_data | input | 8 | Read data, valid one cycle after the request |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: `ea` and `pc_out` are valid |
| ea | output | 64 | Effective address |
| pc_out | output | 64 | Program counter after the operand bytes |

## Verification
Each of the four length selections is driven directly for the short and the absolute tables. A memory whose byte values depend on their address shows whether any byte was skipped, reordered or left in the upper bits. Index values of all ones force 64-bit wrap-around in the indexed and post-indexed modes. Comparing pre-indexed with post-indexed results on the same pointer shows which side of the fetch the index lands on. Random mode codes, prefixes and register values, including the undefined codes, then cover mixed sequences. A second `start` injected during a fetch shows whether requests are dropped while busy.

// File: rtl/eag_pkg.sv
package eag_pkg;

   typedef enum logic [3:0] {
      AM_IMPL = 4'd0,
      AM_IMM  = 4'd1,
      AM_ZP   = 4'd2,
      AM_ZPX  = 4'd3,
      AM_ZPY  = 4'd4,
      AM_IND  = 4'd5,
      AM_INDX = 4'd6,
      AM_INDY = 4'd7,
      AM_ABS  = 4'd8
   } am_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_OPR,
      ST_PTR
   } st_e;

   // operand byte count for the short (zero-page / pointer) modes
   function automatic logic [3:0] short_len(input logic [1:0] sel);
      case (sel)
         2'd0:    return 4'd1;
         2'd1:    return 4'd3;
         2'd2:    return 4'd6;
         default: return 4'd4;
      endcase
   endfunction

   // operand byte count for the absolute mode
   function automatic logic [3:0] long_len(input logic [1:0] sel);
      case (sel)
         2'd0:    return 4'd2;
         2'd1:    return 4'd5;
         2'd2:    return 4'd7;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/eag_len_decode.sv
module eag_len_decode
   import eag_pkg::*;
#(
   parameter int AW = 64,
   parameter int CW = 4
) (
   input  logic [3:0]    mode,
   input  logic [7:0]    prefix,
   input  logic          imm_one,
   output logic [CW-1:0] opr_len,
   output logic [AW-1:0] imm_adv,
   output logic          is_fetch
);

   logic prefix_unused;
   assign prefix_unused = ^prefix[1:0];

   always_comb begin
      opr_len  = '0;
      is_fetch = 1'b0;
      case (mode)
         AM_ZP, AM_ZPX, AM_ZPY, AM_IND, AM_INDX, AM_INDY: begin
            opr_len  = CW'(short_len(prefix[3:2]));
            is_fetch = 1'b1;
         end
         AM_ABS: begin
            opr_len  = CW'(long_len(prefix[3:2]));
            is_fetch = 1'b1;
         end
         default: ;
      endcase
   end

   assign imm_adv = imm_one ? AW'(1) : (AW'(1) << prefix[7:4]);

endmodule

// File: rtl/eag_byte_fetch.sv
module eag_byte_fetch #(
   parameter int AW   = 64,
   parameter int DW   = 8,
   parameter int MAXB = 8,
   parameter int CW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] count,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_data,
   output logic          fin,
   output logic [AW-1:0] value
);

   logic          active;
   logic          pend;
   logic [CW-1:0] iss;
   logic [CW-1:0] cap;
   logic [CW-1:0] n_q;
   logic [AW-1:0] base_q;

   assign mem_rd   = active && (iss < n_q);
   assign mem_addr = base_q + AW'(iss);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         pend   <= 1'b0;
         iss    <= '0;
         cap    <= '0;
         n_q    <= '0;
         base_q <= '0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            active <= 1'b1;
            pend   <= 1'b0;
            iss    <= '0;
            cap    <= '0;
            n_q    <= count;
            base_q <= base;
         end else begin
            if (mem_rd) iss <= iss + CW'(1);
            pend <= mem_rd;
            if (pend) begin
               cap <= cap + CW'(1);
               if (cap == n_q - CW'(1)) begin
                  fin    <= 1'b1;
                  active <= 1'b0;
               end
            end
         end
      end
   end

   // one capture register per byte lane, little-endian placement
   for (genvar g = 0; g < MAXB; g++) begin : g_lane
      logic [DW-1:0] byte_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                          byte_q <= '0;
         else if (go)                         byte_q <= '0;
         else if (pend && cap == CW'(g))      byte_q <= mem_data;
      end
      assign value[g*DW +: DW] = byte_q;
   end

endmodule

// File: rtl/eag_top.sv
module eag_top
   import eag_pkg::*;
#(
   parameter int AW = 64,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    mode,
   input  logic [7:0]    prefix,
   input  logic          imm_one,
   input  logic [AW-1:0] pc_in,
   input  logic [AW-1:0] x_in,
   input  logic [AW-1:0] y_in,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_data,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] pc_out
);

   localparam int MAXB = AW / DW;
   localparam int CW   = $clog2(MAXB + 1);

   if (AW % DW != 0 || MAXB < 8) begin : g_bad_cfg
      $error("eag_top: AW must be a multiple of DW holding at least 8 lanes");
   end

   st_e           st;
   logic [3:0]    mode_q;
   logic [AW-1:0] x_q;
   logic [AW-1:0] y_q;

   logic [CW-1:0] opr_len;
   logic [AW-1:0] imm_adv;
   logic          is_fetch;

   logic          f_go;
   logic [AW-1:0] f_base;
   logic [CW-1:0] f_count;
   logic          f_fin;
   logic [AW-1:0] f_value;

   logic          go_opr;
   logic          go_ptr;
   logic          q_is_ind;
   logic [AW-1:0] idx_pre;
   logic [AW-1:0] idx_post;

   eag_len_decode #(.AW(AW), .CW(CW)) u_len (
      .mode     (mode),
      .prefix   (prefix),
      .imm_one  (imm_one),
      .opr_len  (opr_len),
      .imm_adv  (imm_adv),
      .is_fetch (is_fetch)
   );

   always_comb begin
      q_is_ind = (mode_q == AM_IND) || (mode_q == AM_INDX) || (mode_q == AM_INDY);
      case (mode_q)
         AM_ZPX, AM_INDX: idx_pre = x_q;
         AM_ZPY:          idx_pre = y_q;
         default:         idx_pre = '0;
      endcase
      idx_post = (mode_q == AM_INDY) ? y_q : '0;
   end

   assign go_opr  = start && (st == ST_IDLE) && is_fetch;
   assign go_ptr  = (st == ST_OPR) && f_fin && q_is_ind;
   assign f_go    = go_opr || go_ptr;
   assign f_base  = go_opr ? pc_in : (f_value + idx_pre);
   assign f_count = go_opr ? opr_len : CW'(8);

   eag_byte_fetch #(.AW(AW), .DW(DW), .MAXB(MAXB), .CW(CW)) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (f_go),
      .base     (f_base),
      .count    (f_count),
      .mem_rd   (mem_rd),
      .mem_addr (mem_addr),
      .mem_data (mem_data),
      .fin      (f_fin),
      .value    (f_value)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         mode_q <= AM_IMPL;
         x_q    <= '0;
         y_q    <= '0;
         ea     <= '0;
         pc_out <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  mode_q <= mode;
                  x_q    <= x_in;
                  y_q    <= y_in;
                  if (is_fetch) begin
                     st     <= ST_OPR;
                     pc_out <= pc_in + AW'(opr_len);
                  end else if (mode == AM_IMM) begin
                     ea     <= pc_in;
                     pc_out <= pc_in + imm_adv;
                     done   <= 1'b1;
                  end else begin
                     ea     <= '0;
                     pc_out <= pc_in;
                     done   <= 1'b1;
                  end
               end
            end
            ST_OPR: begin
               if (f_fin) begin
                  if (q_is_ind) begin
                     st <= ST_PTR;
                  end else begin
                     ea   <= f_value + idx_pre;
                     done <= 1'b1;
                     st   <= ST_IDLE;
                  end
               end
            end
            ST_PTR: begin
               if (f_fin) begin
                  ea   <= f_value + idx_post;
                  done <= 1'b1;
                  st   <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);

endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
   parameter int AW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [3:0]    mode,
   input logic [AW-1:0] pc_in,
   input logic          busy,
   input logic          done,
   input logic          mem_rd,
   input logic [AW-1:0] ea,
   input logic [AW-1:0] pc_out
);

   logic [AW-1:0] pc_lat;
   logic [3:0]    mode_lat;
   logic          seen_clk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_lat   <= '0;
         mode_lat <= '0;
         seen_clk <= 1'b0;
      end else begin
         seen_clk <= 1'b1;
         if (start && !busy) begin
            pc_lat   <= pc_in;
            mode_lat <= mode;
         end
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      (!rst_n || !seen_clk) |-> (!busy && !done && !mem_rd));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !mem_rd));

   // R10
   rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> busy);

   // R9
   implied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (mode_lat == 4'd0 || mode_lat > 4'd8)) |-> (ea == '0 && pc_out == pc_lat));

   // R8
   imm_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_lat == 4'd1) |-> (ea == pc_lat));

   // R4
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_lat >= 4'd2 && mode_lat <= 4'd8) |->
         ((pc_out - pc_lat) >= AW'(1) && (pc_out - pc_lat) <= AW'(8)));

endmodule

bind eag_top eag_chk #(.AW(AW)) u_eag_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .mode   (mode),
   .pc_in  (pc_in),
   .busy   (busy),
   .done   (done),
   .mem_rd (mem_rd),
   .ea     (ea),
   .pc_out (pc_out)
);

// File: tb/test_eag_top.sv
module test_eag_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic [7:0]  prefix = '0;
   logic        imm_one = 1'b0;
   logic [63:0] pc_in = '0;
   logic [63:0] x_in = '0;
   logic [63:0] y_in = '0;
   logic        mem_rd;
   logic [63:0] mem_addr;
   logic [7:0]  mem_data = '0;
   logic        busy;
   logic        done;
   logic [63:0] ea;
   logic [63:0] pc_out;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eag_top i_eag_top (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .prefix(prefix),
      .imm_one(imm_one), .pc_in(pc_in), .x_in(x_in), .y_in(y_in),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
      .busy(busy), .done(done), .ea(ea), .pc_out(pc_out)
   );

   function automatic logic [7:0] mbyte(input logic [63:0] a);
      return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ {a[60:57], a[3:0]} ^ 8'hC3;
   endfunction

   // synchronous read memory, one cycle latency
   always @(posedge clk) mem_data <= mem_rd ? mbyte(mem_addr) : 8'h00;

   function automatic logic [63:0] rd_le(input logic [63:0] b, input int n);
      logic [63:0] v = '0;
      for (int i = 0; i < n; i++) v[i*8 +: 8] = mbyte(b + 64'(i));
      return v;
   endfunction

   function automatic int zlen(input logic [1:0] s);
      case (s) 2'd0: return 1; 2'd1: return 3; 2'd2: return 6; default: return 4; endcase
   endfunction

   function automatic int alen(input logic [1:0] s);
      case (s) 2'd0: return 2; 2'd1: return 5; 2'd2: return 7; default: return 8; endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected below 150000", cycles);
         finish_run();
      end
   end

   task automatic run_op(input logic [3:0] m, input logic [7:0] p, input logic io,
                         input logic [63:0] pc, input logic [63:0] x, input logic [63:0] y,
                         input bit interfere);
      logic [63:0] eexp, pexp, a;
      int n, rexp, reads, cyc;
      bit got;
      string req;
      eexp = '0; pexp = pc; rexp = 0; req = "R9";
      case (m)
         4'd1: begin
            n = io ? 1 : (1 << p[7:4]);
            eexp = pc; pexp = pc + 64'(n); req = "R8";
         end
         4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: begin
            n = zlen(p[3:2]); a = rd_le(pc, n); pexp = pc + 64'(n); rexp = n;
            case (m)
               4'd2: begin eexp = a;     req = "R2"; end
               4'd3: begin eexp = a + x; req = "R5"; end
               4'd4: begin eexp = a + y; req = "R5"; end
               4'd5: begin eexp = rd_le(a, 8);     rexp = n + 8; req = "R6"; end
               4'd6: begin eexp = rd_le(a + x, 8); rexp = n + 8; req = "R7"; end
               default: begin eexp = rd_le(a, 8) + y; rexp = n + 8; req = "R7"; end
            endcase
         end
         4'd8: begin
            n = alen(p[3:2]); eexp = rd_le(pc, n); pexp = pc + 64'(n); rexp = n; req = "R3";
         end
         default: ;
      endcase

      @(negedge clk);
      mode = m; prefix = p; imm_one = io; pc_in = pc; x_in = x; y_in = y; start = 1'b1;
      reads = 0; cyc = 0; got = 0;
      while (!got && cyc < 200) begin
         @(negedge clk);
         cyc++;
         if (cyc == 1) start = 1'b0;
         if (interfere && cyc == 2) begin
            start = 1'b1; mode = 4'd8; prefix = 8'h0C; pc_in = ~pc; x_in = ~x; y_in = ~y;
         end
         if (interfere && cyc == 3) start = 1'b0;
         if (mem_rd) reads++;
         if (done) got = 1;
      end
      chk(got, {req, " done seen"}, 64'(cyc), 64'(cyc));
      if (!got) return;
      chk(ea == eexp, req, ea, eexp);
      chk(pc_out == pexp, "R4", pc_out, pexp);
      chk(reads == rexp, "R10 read count", 64'(reads), 64'(rexp));
      if (m < 4'd2 || m > 4'd8)
         chk(cyc == 1, (m == 4'd1) ? "R8 latency" : "R9 latency", 64'(cyc), 64'd1);
      @(negedge clk);
      chk(!done, "R10 done width", 64'(done), 64'd0);
      if (interfere) begin
         bit quiet = 1;
         for (int k = 0; k < 12; k++) begin
            if (mem_rd || done || busy) quiet = 0;
            @(negedge clk);
         end
         chk(quiet, "R11 no trailing activity", 64'(quiet), 64'd1);
      end
   endtask

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      // R1
      chk(!busy && !done && !mem_rd, "R1 in reset", {61'd0, busy, done, mem_rd}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_rd, "R1 after reset", {61'd0, busy, done, mem_rd}, 64'd0);

      // R2: all short-table lengths
      for (int s = 0; s < 4; s++)
         run_op(4'd2, 8'(s << 2), 1'b0, 64'h0000_1234_5678_9A00 + 64'(s*16), '0, '0, 0);
      // R3: all absolute-table lengths
      for (int s = 0; s < 4; s++)
         run_op(4'd8, 8'(s << 2), 1'b0, 64'hFEDC_BA98_7654_3210 + 64'(s*40), '0, '0, 0);
      // R5: indexed with wrap-around
      run_op(4'd3, 8'h04, 1'b0, 64'h100, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 0);
      run_op(4'd4, 8'h0C, 1'b0, 64'h2000, 64'd7, 64'hFFFF_FFFF_FFFF_FFF0, 0);
      // R6, R7: pointer modes on the same operand
      run_op(4'd5, 8'h08, 1'b0, 64'h3_0000, 64'h40, 64'h80, 0);
      run_op(4'd6, 8'h08, 1'b0, 64'h3_0000, 64'h40, 64'h80, 0);
      run_op(4'd7, 8'h08, 1'b0, 64'h3_0000, 64'h40, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      // R8: immediate sizes
      run_op(4'd1, 8'h30, 1'b1, 64'h500, '0, '0, 0);
      run_op(4'd1, 8'h30, 1'b0, 64'h500, '0, '0, 0);
      run_op(4'd1, 8'hF0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF8, '0, '0, 0);
      // R9: implied, defined and undefined codes
      run_op(4'd0, 8'hFF, 1'b0, 64'h777, 64'h1, 64'h2, 0);
      run_op(4'd12, 8'h5C, 1'b0, 64'h888, 64'h1, 64'h2, 0);
      // R11: start while busy
      run_op(4'd6, 8'h0C, 1'b0, 64'h4_4444, 64'h10, 64'h20, 1);
      run_op(4'd8, 8'h0C, 1'b0, 64'h9_0000, 64'h10, 64'h20, 1);

      // random mix
      for (int i = 0; i < 150; i++) begin
         logic [3:0]  rm = 4'($urandom_range(0, 15));
         logic [7:0]  rp = 8'($urandom);
         logic [63:0] rpc = {$urandom, $urandom};
         logic [63:0] rx  = {$urandom, $urandom};
         logic [63:0] ry  = {$urandom, $urandom};
         run_op(rm, rp, 1'($urandom), rpc, rx, ry, 0);
      end

      finish_run();
   end

endmodule